// File: doc/BRIEF.md
# Segment Translation Hash Generator

This block turns an effective address and the descriptor word of the segment that address falls in into the values a page-table walker needs to probe a hashed page table. It returns the primary hash, the word that a candidate table entry must match, the protection key that applies, and the no-execute flag. The caller does not have to know the segment size or the page size in advance, because both come from fields of the descriptor word.

Segments may span 256MB or 1TB, and pages may be 4KB or 16MB. The segment size changes three things: the shift that extracts the virtual segment identifier, the number of effective-address bits that form the segment offset, and the hash. For 1TB segments, a copy of the identifier shifted left is folded into the hash. The datapath is a single registered stage. A result pulse appears on the cycle after each accepted input, and the outputs hold their values between pulses.

Top module: `seghash_gen`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high and is low otherwise. While `rst_n` is low, `out_valid`, `hash`, `match_word`, `prot_key` and `no_exec` are all zero.
- R2: Descriptor bits 63:62 select the segment size: 00 means 256MB (28 offset bits) and any other value means 1TB (40 offset bits). The identifier is descriptor bits 61:12 shifted down by 12 for 256MB and by 24 for 1TB.
- R3: Descriptor bit 8 set selects 16MB pages (24 page-offset bits). Clear selects 4KB pages (12 bits). The page address is the effective address ANDed with 2^seg_bits − 2^page_bits.
- R4: For a 256MB segment, the hash is identifier XOR (page address >> page_bits).
- R5: For a 1TB segment, the hash is identifier XOR (identifier << 25) XOR (page address >> page_bits).
- R6: `match_word` is the descriptor with bits 11:0 cleared, ORed with (page address >> 16) AND (2^seg_bits − 0x80). Its bits 6:0 are therefore always zero.
- R7: `prot_key` is descriptor bit 10 when `user_mode` is 1 and descriptor bit 11 when it is 0.
- R8: `no_exec` is descriptor bit 9.
- R9: When `in_valid` is low, `hash`, `match_word`, `prot_key` and `no_exec` keep their values whatever the other inputs do.
- R10: `hash` is bits 38:0 of the full hash. Identifier bits that the fold moves above bit 38 do not reach the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| eff_addr | input | 64 | Effective address |
| seg_word | input | 64 | Segment descriptor word |
| user_mode | input | 1 | Problem-state access |
| out_valid | output | 1 | Result valid |
| hash | output | 39 | Primary hash |
| match_word | output | 64 | Table-entry match word |
| prot_key | output | 1 | Selected protection key |
| no_exec | output | 1 | No-execute flag |

## Verification
The bench builds the block with its default parameters: 64-bit words, a 39-bit hash, and 1TB segment support enabled. With these values, all four combinations of segment size and page size can be reached, including the folded hash. Identifiers are chosen with high bits set, so the fold produces bits above the hash width and the truncation is exercised. Descriptors with the size field set to 10 and 11 confirm that every nonzero encoding is treated as a 1TB segment.

// File: rtl/seghash_pkg.sv
package seghash_pkg;
   localparam int SIZE_HI  = 63;
   localparam int SIZE_LO  = 62;
   localparam int VSID_HI  = 61;
   localparam int VSID_LO  = 12;
   localparam int KS_BIT   = 11;
   localparam int KP_BIT   = 10;
   localparam int NX_BIT   = 9;
   localparam int LP_BIT   = 8;

   typedef enum logic {SEG_SMALL = 1'b0, SEG_LARGE = 1'b1} seg_size_e;
endpackage

// File: rtl/seghash_decode.sv
module seghash_decode
   import seghash_pkg::*;
#(
   parameter int ADDR_W           = 64,
   parameter int HASH_W           = 39,
   parameter int SMALL_SEG_BITS   = 28,
   parameter int LARGE_SEG_BITS   = 40,
   parameter int SMALL_PAGE_BITS  = 12,
   parameter int LARGE_PAGE_BITS  = 24,
   parameter int LARGE_VSID_SHIFT = 24,
   parameter int AVPN_SHIFT       = 16,
   parameter int AVPN_FLOOR       = 7,
   parameter bit LARGE_SEG_EN     = 1'b1
) (
   input  logic [ADDR_W-1:0] eff_addr,
   input  logic [ADDR_W-1:0] seg_word,
   output logic              large_seg,
   output logic [HASH_W-1:0] vsid,
   output logic [HASH_W-1:0] page_idx,
   output logic [ADDR_W-1:0] avpn_part
);
   localparam logic [ADDR_W-1:0] ONES      = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] VSID_MASK = (ONES >> (ADDR_W - 1 - VSID_HI)) & (ONES << VSID_LO);
   localparam logic [ADDR_W-1:0] S_SPAN    = ONE << SMALL_SEG_BITS;
   localparam logic [ADDR_W-1:0] L_SPAN    = ONE << LARGE_SEG_BITS;
   localparam logic [ADDR_W-1:0] SP_SPAN   = ONE << SMALL_PAGE_BITS;
   localparam logic [ADDR_W-1:0] LP_SPAN   = ONE << LARGE_PAGE_BITS;
   localparam logic [ADDR_W-1:0] FLOOR_V   = ONE << AVPN_FLOOR;

   seg_size_e         seg_sz;
   logic              big_page;
   logic [ADDR_W-1:0] vfield;
   logic [ADDR_W-1:0] seg_span;
   logic [ADDR_W-1:0] page_span;
   logic [ADDR_W-1:0] page_addr;

   generate
      if (LARGE_SEG_EN) begin : g_two_sizes
         assign seg_sz = (|seg_word[SIZE_HI:SIZE_LO]) ? SEG_LARGE : SEG_SMALL;
      end else begin : g_small_only
         assign seg_sz = SEG_SMALL;
      end
   endgenerate

   assign large_seg = (seg_sz == SEG_LARGE);
   assign big_page  = seg_word[LP_BIT];

   always_comb begin
      vfield    = seg_word & VSID_MASK;
      seg_span  = large_seg ? L_SPAN : S_SPAN;
      page_span = big_page ? LP_SPAN : SP_SPAN;
      page_addr = eff_addr & (seg_span - page_span);
      vsid      = large_seg ? HASH_W'(vfield >> LARGE_VSID_SHIFT)
                            : HASH_W'(vfield >> VSID_LO);
      page_idx  = big_page ? HASH_W'(page_addr >> LARGE_PAGE_BITS)
                           : HASH_W'(page_addr >> SMALL_PAGE_BITS);
      avpn_part = (page_addr >> AVPN_SHIFT) & (seg_span - FLOOR_V);
   end
endmodule

// File: rtl/seghash_mix.sv
module seghash_mix #(
   parameter int HASH_W       = 39,
   parameter int FOLD_SHIFT   = 25,
   parameter bit LARGE_SEG_EN = 1'b1
) (
   input  logic [HASH_W-1:0] vsid,
   input  logic [HASH_W-1:0] page_idx,
   input  logic              large_seg,
   output logic [HASH_W-1:0] hash
);
   generate
      if (LARGE_SEG_EN) begin : g_fold
         logic [HASH_W-1:0] folded;
         assign folded = large_seg ? (vsid << FOLD_SHIFT) : '0;
         assign hash   = vsid ^ folded ^ page_idx;
      end else begin : g_plain
         logic unused_sel;
         assign unused_sel = large_seg;
         assign hash       = vsid ^ page_idx;
      end
   endgenerate
endmodule

// File: rtl/seghash_gen.sv
module seghash_gen
   import seghash_pkg::*;
#(
   parameter int ADDR_W           = 64,
   parameter int HASH_W           = 39,
   parameter int SMALL_SEG_BITS   = 28,
   parameter int LARGE_SEG_BITS   = 40,
   parameter int SMALL_PAGE_BITS  = 12,
   parameter int LARGE_PAGE_BITS  = 24,
   parameter int LARGE_VSID_SHIFT = 24,
   parameter int FOLD_SHIFT       = 25,
   parameter int AVPN_SHIFT       = 16,
   parameter int AVPN_FLOOR       = 7,
   parameter bit LARGE_SEG_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] eff_addr,
   input  logic [ADDR_W-1:0] seg_word,
   input  logic              user_mode,
   output logic              out_valid,
   output logic [HASH_W-1:0] hash,
   output logic [ADDR_W-1:0] match_word,
   output logic              prot_key,
   output logic              no_exec
);
   localparam logic [ADDR_W-1:0] MATCH_MASK = {ADDR_W{1'b1}} << VSID_LO;

   initial begin : chk_params
      assert (ADDR_W > VSID_HI + 1)
         else $fatal(1, "ADDR_W too narrow for descriptor fields");
      assert (HASH_W > 0 && HASH_W <= ADDR_W)
         else $fatal(1, "HASH_W out of range");
      assert (SMALL_PAGE_BITS < LARGE_PAGE_BITS && LARGE_PAGE_BITS < SMALL_SEG_BITS)
         else $fatal(1, "page sizes must nest inside the small segment");
      assert (SMALL_SEG_BITS < LARGE_SEG_BITS && LARGE_SEG_BITS < ADDR_W)
         else $fatal(1, "segment sizes out of order");
   end

   logic              large_seg;
   logic [HASH_W-1:0] vsid;
   logic [HASH_W-1:0] page_idx;
   logic [ADDR_W-1:0] avpn_part;
   logic [HASH_W-1:0] hash_d;

   seghash_decode #(
      .ADDR_W(ADDR_W), .HASH_W(HASH_W),
      .SMALL_SEG_BITS(SMALL_SEG_BITS), .LARGE_SEG_BITS(LARGE_SEG_BITS),
      .SMALL_PAGE_BITS(SMALL_PAGE_BITS), .LARGE_PAGE_BITS(LARGE_PAGE_BITS),
      .LARGE_VSID_SHIFT(LARGE_VSID_SHIFT), .AVPN_SHIFT(AVPN_SHIFT),
      .AVPN_FLOOR(AVPN_FLOOR), .LARGE_SEG_EN(LARGE_SEG_EN)
   ) u_decode (
      .eff_addr  (eff_addr),
      .seg_word  (seg_word),
      .large_seg (large_seg),
      .vsid      (vsid),
      .page_idx  (page_idx),
      .avpn_part (avpn_part)
   );

   seghash_mix #(
      .HASH_W(HASH_W), .FOLD_SHIFT(FOLD_SHIFT), .LARGE_SEG_EN(LARGE_SEG_EN)
   ) u_mix (
      .vsid      (vsid),
      .page_idx  (page_idx),
      .large_seg (large_seg),
      .hash      (hash_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         hash       <= '0;
         match_word <= '0;
         prot_key   <= 1'b0;
         no_exec    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            hash       <= hash_d;
            match_word <= (seg_word & MATCH_MASK) | avpn_part;
            prot_key   <= user_mode ? seg_word[KP_BIT] : seg_word[KS_BIT];
            no_exec    <= seg_word[NX_BIT];
         end
      end
   end
endmodule

// File: rtl/seghash_chk.sv
module seghash_chk #(
   parameter int ADDR_W = 64,
   parameter int HASH_W = 39
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [ADDR_W-1:0] seg_word,
   input logic              user_mode,
   input logic              out_valid,
   input logic [HASH_W-1:0] hash,
   input logic [ADDR_W-1:0] match_word,
   input logic              prot_key,
   input logic              no_exec
);
   p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_valid_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_match_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (match_word[6:0] == 7'd0));
   p_match_top_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (match_word[ADDR_W-1:24] == $past(seg_word[ADDR_W-1:24])));
   p_key_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (prot_key == ($past(user_mode) ? $past(seg_word[10]) : $past(seg_word[11]))));
   p_nx_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (no_exec == $past(seg_word[9])));
   p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(hash) && $stable(match_word) && $stable(prot_key) && $stable(no_exec)));
endmodule

bind seghash_gen seghash_chk #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .seg_word   (seg_word),
   .user_mode  (user_mode),
   .out_valid  (out_valid),
   .hash       (hash),
   .match_word (match_word),
   .prot_key   (prot_key),
   .no_exec    (no_exec)
);

// File: tb/sim_seghash_gen.sv
module sim_seghash_gen;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] eff_addr = '0;
   logic [63:0] seg_word = '0;
   logic        user_mode = 1'b0;
   logic        out_valid;
   logic [38:0] hash;
   logic [63:0] match_word;
   logic        prot_key;
   logic        no_exec;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   seghash_gen u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .eff_addr(eff_addr), .seg_word(seg_word), .user_mode(user_mode),
      .out_valid(out_valid), .hash(hash), .match_word(match_word),
      .prot_key(prot_key), .no_exec(no_exec)
   );

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic void ref_calc(input logic [63:0] ea, input logic [63:0] w, input logic u,
                                    output logic [38:0] h, output logic [63:0] m,
                                    output logic k, output logic nx);
      logic        big;
      logic [63:0] vf, v, pa, full;
      int          sb, pb;
      big  = (w[63:62] != 2'b00);
      vf   = w & 64'h3FFF_FFFF_FFFF_F000;
      v    = big ? (vf >> 24) : (vf >> 12);
      sb   = big ? 40 : 28;
      pb   = w[8] ? 24 : 12;
      pa   = ea & ((64'd1 << sb) - (64'd1 << pb));
      full = v ^ (big ? (v << 25) : 64'd0) ^ (pa >> pb);
      h    = full[38:0];
      m    = (w & 64'hFFFF_FFFF_FFFF_F000) | ((pa >> 16) & ((64'd1 << sb) - 64'h80));
      k    = u ? w[10] : w[11];
      nx   = w[9];
   endfunction

   task automatic apply_check(input string req, input logic [63:0] ea, input logic [63:0] w, input logic u);
      logic [38:0] eh;
      logic [63:0] em;
      logic        ek, enx;
      ref_calc(ea, w, u, eh, em, ek, enx);
      @(negedge clk);
      eff_addr = ea; seg_word = w; user_mode = u; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(req, "out_valid", {63'd0, out_valid}, 64'd1);
      chk(req, "hash", {25'd0, hash}, {25'd0, eh});
      chk(req, "match_word", match_word, em);
      chk(req, "prot_key", {63'd0, prot_key}, {63'd0, ek});
      chk(req, "no_exec", {63'd0, no_exec}, {63'd0, enx});
      @(negedge clk);
      chk("R1", "out_valid drop", {63'd0, out_valid}, 64'd0);
   endtask

   task automatic t_reset;
      chk("R1", "reset out_valid", {63'd0, out_valid}, 64'd0);
      chk("R1", "reset hash", {25'd0, hash}, 64'd0);
      chk("R1", "reset match_word", match_word, 64'd0);
      chk("R1", "reset key", {62'd0, prot_key, no_exec}, 64'd0);
   endtask

   task automatic t_small_4k;   // R2 R3 R4 R6
      apply_check("R4", 64'h0000_1234_5ABC_DEF0, 64'h0000_0ABC_DEF1_2000, 1'b0);
      apply_check("R6", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0012_3456_789A_B000, 1'b0);
   endtask

   task automatic t_small_16m;  // R3
      apply_check("R3", 64'h0000_0000_0F80_0123, 64'h0000_0000_5555_5100, 1'b0);
   endtask

   task automatic t_large_4k;   // R2 R5
      apply_check("R5", 64'h0000_00AB_CDEF_1234, 64'h4000_0012_3400_0000, 1'b0);
      apply_check("R2", 64'h0000_0055_5555_5000, 64'h8000_0000_0100_0000, 1'b1);
      apply_check("R2", 64'h0000_00FF_FFFF_F000, 64'hC000_0000_0200_0000, 1'b0);
   endtask

   task automatic t_large_16m;  // R3 R5 R6
      apply_check("R5", 64'h0000_00FF_FFFF_FFFF, 64'h4000_0000_0300_0100, 1'b0);
   endtask

   task automatic t_trunc;      // R10
      apply_check("R10", 64'h0000_0012_3456_7000, 64'h7FFF_FFFF_FFFF_F000, 1'b0);
   endtask

   task automatic t_flags;      // R7 R8
      apply_check("R7", 64'h0, 64'h0000_0000_0000_0400, 1'b1);
      apply_check("R7", 64'h0, 64'h0000_0000_0000_0800, 1'b1);
      apply_check("R7", 64'h0, 64'h0000_0000_0000_0800, 1'b0);
      apply_check("R8", 64'h0, 64'h0000_0000_0000_0200, 1'b0);
   endtask

   task automatic t_hold;       // R9
      logic [38:0] h0;
      logic [63:0] m0;
      logic        k0, x0;
      apply_check("R9", 64'h0000_0001_2345_6789, 64'h0000_0FED_CBA9_8E00, 1'b1);
      h0 = hash; m0 = match_word; k0 = prot_key; x0 = no_exec;
      @(negedge clk);
      eff_addr = 64'hDEAD_BEEF_CAFE_F00D; seg_word = 64'h4123_4567_89AB_CF00; user_mode = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R9", "hold out_valid", {63'd0, out_valid}, 64'd0);
      chk("R9", "hold hash", {25'd0, hash}, {25'd0, h0});
      chk("R9", "hold match_word", match_word, m0);
      chk("R9", "hold flags", {62'd0, prot_key, no_exec}, {62'd0, k0, x0});
   endtask

   initial begin : watchdog
      #(CLK_P * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_small_4k();
      t_small_16m();
      t_large_4k();
      t_large_16m();
      t_trunc();
      t_flags();
      t_hold();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule